// File: doc/BRIEF.md
# Per-CPU Interrupt Level Aggregator

This block is the processor-side part of a level-based interrupt controller. One copy sits beside each CPU. It keeps a small local pending word that holds software-raised interrupts, a processor timer bit and a level-15 bit. It merges that word with the hard-interrupt level vector that a system router computes, and drives fifteen active-high interrupt level lines (levels 1 to 15) to the processor, together with a 4-bit code for the highest active level.

Software reaches the block through a small 32-bit register window. One word reads the pending view. One word clears pending bits when ones are written to it. One word raises soft interrupts. Soft interrupts live in the upper half of the word and map down to levels by a shift of 16. The timer and level-15 bits are gated only by the global master-disable input. When this CPU is the current routing target, the pending view also shows the hard levels that raw system sources map to, even while those sources are masked.

Top module: `cpu_irq_level_unit`

## Requirements
- R1: Register window, decoded on byte address bits 3:2 and returned on `rd_data` one cycle after `rd_en`. Word 0 (0x0) reads the pending view. Words 1, 2 and 3 (0x4, 0x8, 0xC) read as zero. `rd_data` holds its value while `rd_en` is low.
- R2: A write to word 2 (0x8) sets the soft bits 31:17 where the data has ones. All other data bits are discarded.
- R3: A write to word 1 (0x4) clears soft bits 31:17 and bit 15 where the data has ones. Bit 14 and all other bits are unaffected. Writes to words 0 and 3 change no state.
- R4: Bit 14 of the pending view is the timer input sampled at the previous clock edge.
- R5: Bit 15 is set when `lvl15_in` rises and cleared when it falls. Between those edges a clear write may drop it. If a rise and a clear write arrive in the same cycle, the rise wins.
- R6: Soft bit N+16 drives level N (N = 1..15), whatever the state of `master_disable`.
- R7: While `master_disable` is high, the timer bit, bit 15 and the hard levels are kept off the level outputs. Only soft levels remain.
- R8: `hard_live` bit N drives level N only while `is_target` is high and `master_disable` is low.
- R9: While `is_target` is high, the pending view also ORs in `hard_raw` bits 15:1, whatever the masking. These bits are not stored, so they vanish as soon as `is_target` drops.
- R10: Level 0 does not exist. `level_out[0]` is always 0, and `hard_raw[0]`/`hard_live[0]` have no effect on any output.
- R11: `irl_code` gives the highest set bit of `level_out` (15 down to 1), or 0 when no level is set.
- R12: A synchronous reset clears the pending state, `level_out`, `irl_code` and `rd_data`.
- R13: `level_out` and `irl_code` show the effect of the inputs and writes present at a clock edge immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address inside the window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| timer_in | input | 1 | Per-CPU timer interrupt level |
| lvl15_in | input | 1 | System level-15 source level |
| master_disable | input | 1 | Global disable for timer, level-15 and hard levels |
| is_target | input | 1 | This CPU is the current hard-interrupt target |
| hard_live | input | 16 | Masked hard levels for output (bit N = level N) |
| hard_raw | input | 16 | Unmasked mapped hard levels for the pending view |
| level_out | output | 16 | Registered level lines, bit 0 always 0 |
| irl_code | output | 4 | Registered encoded highest level |

## Verification
The assertions assume one write per cycle through the single window, and that the routing inputs are plain levels that may change on any cycle, bit 0 included. They also assume that reset is held for at least one edge before any checked cycle. The stimulus drives every input at the falling edge, so each rising edge sees a stable set. It keeps addresses word-aligned inside the window. It toggles `lvl15_in` sparsely, so that clear writes land both between its edges and on top of a rising edge.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  typedef enum logic [1:0] {
    WIN_VIEW = 2'd0,
    WIN_CLR  = 2'd1,
    WIN_SET  = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  localparam int WIN_LSB = 2;
endpackage

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int SOFT_LO = 17,
  parameter int TMR_BIT = 14,
  parameter int TOP_BIT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              timer_in,
  input  logic              lvl15_in,
  output logic [DATA_W-1:0] state_q,
  output logic [DATA_W-1:0] state_d
);
  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
  localparam logic [DATA_W-1:0] SOFT_MASK = ~((ONE << SOFT_LO) - ONE);

  win_e win;
  logic wr_set, wr_clr;
  logic [DATA_W-1:0] soft_q, soft_d;
  logic top_q, top_d, top_prev_q, tmr_q;

  assign win    = win_e'(addr[WIN_LSB +: 2]);
  assign wr_set = wr_en && (win == WIN_SET);
  assign wr_clr = wr_en && (win == WIN_CLR);

  always_comb begin
    soft_d = soft_q;
    if (wr_clr) soft_d = soft_d & ~(wr_data & SOFT_MASK);
    if (wr_set) soft_d = soft_d | (wr_data & SOFT_MASK);
    top_d = top_q;
    if (lvl15_in && !top_prev_q)                top_d = 1'b1;
    else if (!lvl15_in && top_prev_q)           top_d = 1'b0;
    else if (wr_clr && wr_data[TOP_BIT])        top_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q     <= '0;
      top_q      <= 1'b0;
      top_prev_q <= 1'b0;
      tmr_q      <= 1'b0;
    end else begin
      soft_q     <= soft_d;
      top_q      <= top_d;
      top_prev_q <= lvl15_in;
      tmr_q      <= timer_in;
    end
  end

  always_comb begin
    state_q          = soft_q;
    state_q[TOP_BIT] = top_q;
    state_q[TMR_BIT] = tmr_q;
    state_d          = soft_d;
    state_d[TOP_BIT] = top_d;
    state_d[TMR_BIT] = timer_in;
  end

  // R2: set write lands in the soft field on the next cycle
  assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(addr[WIN_LSB +: 2]) == 2'd2)
      |-> ((state_q & $past(wr_data) & SOFT_MASK) == ($past(wr_data) & SOFT_MASK)));

  // R3: clear write leaves no selected soft bit standing
  assert_clear_soft_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(addr[WIN_LSB +: 2]) == 2'd1)
      |-> ((state_q & $past(wr_data) & SOFT_MASK) == '0));

  // R4: timer bit tracks the input one edge late
  assert_timer_follow_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (state_q[TMR_BIT] == $past(timer_in)));

  // R5: rising level-15 input always sets bit 15
  assert_top_rise_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 2) && !$past(rst) && $rose(lvl15_in)) |=> state_q[TOP_BIT]);
endmodule

// File: rtl/lirq_merge.sv
module lirq_merge #(
  parameter int DATA_W  = 32,
  parameter int NUM_LVL = 16,
  parameter int SHIFT   = 16,
  parameter int TMR_BIT = 14,
  parameter int TOP_BIT = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  state_d,
  input  logic               master_disable,
  input  logic               is_target,
  input  logic [NUM_LVL-1:0] hard_live,
  output logic [NUM_LVL-1:0] level_d,
  output logic [NUM_LVL-1:0] level_q
);
  logic [NUM_LVL-1:0] soft_lvl;

  for (genvar n = 0; n < NUM_LVL; n++) begin : g_lvl
    if (n == 0) begin : g_zero
      assign soft_lvl[n] = 1'b0;
      assign level_d[n]  = 1'b0;
    end else begin : g_real
      logic local_bit;
      if (n + SHIFT < DATA_W) begin : g_soft
        assign soft_lvl[n] = state_d[n + SHIFT];
      end else begin : g_nosoft
        assign soft_lvl[n] = 1'b0;
      end
      if (n == TMR_BIT || n == TOP_BIT) begin : g_loc
        assign local_bit = state_d[n];
      end else begin : g_noloc
        assign local_bit = 1'b0;
      end
      assign level_d[n] = soft_lvl[n]
                        | (!master_disable && local_bit)
                        | (!master_disable && is_target && hard_live[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_d;
  end

  // R6 R7: under master disable only soft levels reach the lines
  assert_md_soft_only_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(master_disable))
      |-> (level_q == NUM_LVL'({$past(state_d) >> SHIFT} & ~DATA_W'(1))));

  // R10: level zero never driven
  assert_no_level0_R10: assert property (@(posedge clk) !level_q[0]);
endmodule

// File: rtl/lirq_prio.sv
module lirq_prio #(
  parameter int NUM_LVL = 16,
  parameter int CODE_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] level_d,
  output logic [CODE_W-1:0]  code_q
);
  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = '0;
    for (int i = 1; i < NUM_LVL; i++) begin
      if (level_d[i]) code_d = CODE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_d;
  end
endmodule

// File: rtl/lirq_view.sv
module lirq_view
  import lirq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int NUM_LVL = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  state_q,
  input  logic               is_target,
  input  logic [NUM_LVL-1:0] hard_raw,
  output logic [DATA_W-1:0]  rd_data
);
  localparam logic [NUM_LVL-1:0] LVL_MASK = ~NUM_LVL'(1);

  win_e win;
  logic [DATA_W-1:0] view;

  assign win  = win_e'(addr[WIN_LSB +: 2]);
  assign view = state_q | (is_target ? DATA_W'(hard_raw & LVL_MASK) : '0);

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= (win == WIN_VIEW) ? view : '0;
  end

  // R1: the unused words always return zero
  assert_empty_words_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(addr[WIN_LSB +: 2]) != 2'd0) |-> (rd_data == '0));

  // R1: data holds between reads
  assert_rd_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));
endmodule

// File: rtl/cpu_irq_level_unit.sv
module cpu_irq_level_unit #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int NUM_LVL = 16,
  parameter int SHIFT   = 16,
  parameter int TMR_BIT = 14,
  parameter int TOP_BIT = 15,
  parameter int CODE_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               timer_in,
  input  logic               lvl15_in,
  input  logic               master_disable,
  input  logic               is_target,
  input  logic [NUM_LVL-1:0] hard_live,
  input  logic [NUM_LVL-1:0] hard_raw,
  output logic [NUM_LVL-1:0] level_out,
  output logic [CODE_W-1:0]  irl_code
);
  localparam int SOFT_LO = SHIFT + 1;

  logic [DATA_W-1:0]  state_q, state_d;
  logic [NUM_LVL-1:0] level_d;

  lirq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SOFT_LO(SOFT_LO),
    .TMR_BIT(TMR_BIT), .TOP_BIT(TOP_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .timer_in(timer_in), .lvl15_in(lvl15_in),
    .state_q(state_q), .state_d(state_d)
  );

  lirq_merge #(
    .DATA_W(DATA_W), .NUM_LVL(NUM_LVL), .SHIFT(SHIFT),
    .TMR_BIT(TMR_BIT), .TOP_BIT(TOP_BIT)
  ) u_merge (
    .clk(clk), .rst(rst), .state_d(state_d), .master_disable(master_disable),
    .is_target(is_target), .hard_live(hard_live),
    .level_d(level_d), .level_q(level_out)
  );

  lirq_prio #(.NUM_LVL(NUM_LVL), .CODE_W(CODE_W)) u_prio (
    .clk(clk), .rst(rst), .level_d(level_d), .code_q(irl_code)
  );

  lirq_view #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL)) u_view (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .state_q(state_q),
    .is_target(is_target), .hard_raw(hard_raw), .rd_data(rd_data)
  );

  // R11: code names a set line with nothing set above it
  assert_code_top_R11: assert property (@(posedge clk) disable iff (rst)
    (irl_code != '0) |-> (level_out[irl_code] && ((level_out >> irl_code) == NUM_LVL'(1))));

  // R11: zero code means idle lines
  assert_code_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (irl_code == '0) |-> (level_out == '0));

  // R12: a reset edge leaves outputs cleared
  assert_reset_clear_R12: assert property (@(posedge clk)
    $past(rst) |-> (level_out == '0 && irl_code == '0 && rd_data == '0));
endmodule

// File: tb/test_cpu_irq_level_unit.sv
module test_cpu_irq_level_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        timer_in = 1'b0, lvl15_in = 1'b0, master_disable = 1'b0, is_target = 1'b0;
  logic [15:0] hard_live = '0, hard_raw = '0;
  logic [15:0] level_out;
  logic [3:0]  irl_code;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] SOFT = 32'hFFFE_0000;

  logic [31:0] m_soft;
  logic m_b15, m_prev15, m_tmr;
  logic [15:0] e_lvl;
  logic [3:0]  e_code;
  logic [31:0] e_rd;
  bit have_exp;

  always #5 clk = ~clk;

  cpu_irq_level_unit i_cpu_irq_level_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .timer_in(timer_in), .lvl15_in(lvl15_in),
    .master_disable(master_disable), .is_target(is_target), .hard_live(hard_live),
    .hard_raw(hard_raw), .level_out(level_out), .irl_code(irl_code)
  );

  function automatic logic [3:0] top_code(input logic [15:0] v);
    top_code = '0;
    for (int i = 1; i < 16; i++) if (v[i]) top_code = 4'(i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    if (have_exp) begin
      chk("R6 R7 R8 R10 R13 level_out", 32'(level_out), 32'(e_lvl));
      chk("R11 irl_code", 32'(irl_code), 32'(e_code));
      chk("R1 R9 rd_data", rd_data, e_rd);
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic [3:0] a, input logic [31:0] d,
                      input logic tmr, input logic l15, input logic md, input logic tgt,
                      input logic [15:0] hraw, input logic [15:0] hlive);
    logic [31:0] view, nsoft;
    logic nb15, ws, wc;
    logic [15:0] lvl;
    @(negedge clk);
    check_outputs();
    wr_en = wr; rd_en = rd; addr = a; wr_data = d; timer_in = tmr; lvl15_in = l15;
    master_disable = md; is_target = tgt; hard_raw = hraw; hard_live = hlive;
    view = m_soft | (32'(m_b15) << 15) | (32'(m_tmr) << 14) | (tgt ? 32'(hraw & 16'hFFFE) : 32'h0);
    if (rd) e_rd = (a[3:2] == 2'd0) ? view : 32'h0;
    ws = wr && a[3:2] == 2'd2;
    wc = wr && a[3:2] == 2'd1;
    nsoft = m_soft;
    if (wc) nsoft = nsoft & ~(d & SOFT);
    if (ws) nsoft = nsoft | (d & SOFT);
    if (l15 && !m_prev15)       nb15 = 1'b1;
    else if (!l15 && m_prev15)  nb15 = 1'b0;
    else if (wc && d[15])       nb15 = 1'b0;
    else                        nb15 = m_b15;
    lvl = 16'(nsoft >> 16);
    if (!md) begin
      lvl[15] = lvl[15] | nb15;
      lvl[14] = lvl[14] | tmr;
      if (tgt) lvl = lvl | hlive;
    end
    lvl[0] = 1'b0;
    e_lvl = lvl; e_code = top_code(lvl);
    m_soft = nsoft; m_b15 = nb15; m_prev15 = l15; m_tmr = tmr;
    have_exp = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_soft = '0; m_b15 = 0; m_prev15 = 0; m_tmr = 0;
    e_lvl = '0; e_code = '0; e_rd = '0; have_exp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk("R12 level_out", 32'(level_out), 32'h0);
    chk("R12 irl_code", 32'(irl_code), 32'h0);
    chk("R12 rd_data", rd_data, 32'h0);
    // R2: set all bits, only soft field kept; R6 levels 1..15 raised
    step(1, 0, 4'h8, 32'hFFFF_FFFF, 0, 0, 1, 0, 0, 0);
    step(0, 1, 4'h0, 0, 0, 0, 1, 0, 0, 0);
    // R3: clear soft bit 31 and bits 14..0 (no effect on low bits)
    step(1, 0, 4'h4, 32'h8000_7FFF, 1, 0, 0, 0, 0, 0);
    step(0, 1, 4'h0, 0, 1, 0, 0, 0, 0, 0);
    // R1: empty words read zero
    step(0, 1, 4'hC, 0, 1, 0, 0, 0, 0, 0);
    step(0, 1, 4'h4, 0, 1, 0, 0, 0, 0, 0);
    // R3: writes to words 0 and 3 ignored
    step(1, 0, 4'h0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    step(1, 1, 4'hC, 32'h0000_0000, 0, 0, 0, 0, 0, 0);
    step(0, 1, 4'h0, 0, 0, 0, 0, 0, 0, 0);
    // clear all soft
    step(1, 0, 4'h4, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    // R5: rise, clear by write, then rise with simultaneous clear
    step(0, 0, 4'h0, 0, 0, 1, 0, 0, 0, 0);
    step(1, 0, 4'h4, 32'h0000_8000, 0, 1, 0, 0, 0, 0);
    step(0, 1, 4'h0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 4'h4, 32'h0000_8000, 0, 1, 0, 0, 0, 0);
    step(0, 1, 4'h0, 0, 0, 1, 1, 0, 0, 0);
    step(0, 1, 4'h0, 0, 0, 0, 0, 0, 0, 0);
    // R8 R9 R10: target with bit 0 set on hard inputs, masked and not
    step(0, 1, 4'h0, 0, 0, 0, 0, 1, 16'hFFFF, 16'h0001);
    step(0, 1, 4'h0, 0, 0, 0, 1, 1, 16'h4321, 16'h4321);
    step(0, 1, 4'h0, 0, 0, 0, 0, 0, 16'hFFFF, 16'hFFFF);
    step(0, 1, 4'h0, 0, 0, 0, 0, 1, 16'h0000, 16'h2005);
    // R4 R7: timer under disable
    step(0, 1, 4'h0, 0, 1, 0, 1, 0, 0, 0);
    step(0, 1, 4'h0, 0, 1, 0, 0, 0, 0, 0);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic l15n;
      l15n = (($urandom % 8) == 0) ? ~m_prev15 : m_prev15;
      step(($urandom % 3) == 0, ($urandom % 2) == 0, 4'(($urandom % 4) * 4), $urandom,
           ($urandom % 4) == 0, l15n, ($urandom % 4) == 0, ($urandom % 2) == 0,
           16'($urandom), 16'($urandom & $urandom));
    end
    @(negedge clk);
    check_outputs();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule